// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This unit carries out one data-processing operation on each clock edge. It receives a 4-bit operation code and a first operand. It also receives a second operand that an external shifter has already processed, together with the carry bit that shifter produced. It takes a request to set flags and the current negative, zero, carry and overflow flags. At the next edge it presents a registered 32-bit result, a destination write strobe and the next flag values. An integer pipeline uses it in its execute stage.

There are eleven operations. The arithmetic group is add, subtract, reverse subtract and compare. The bitwise group is move, OR, AND, exclusive OR, bit clear, test and test-equivalence. The three comparison forms never write a destination, and they always update the flags. The other operations change the flags only when asked to.

Top module: `dp_alu_unit`

## Requirements
- R1: While `rst_n` is low, `result_q`, `dest_we_q` and `flags_q` are all zero.
- R2: Arithmetic codes are ADD=1 (a+b), SUB=2 (a-b), RSB=3 (b-a) and CMP=8 (a-b). All are taken modulo 2^32. RSB with b=0 and a=0x77 gives 0xFFFFFF89.
- R3: Bitwise codes are MOV=0 (b), ORR=4 (a|b), AND=5 (a&b), EOR=6 (a^b), BIC=7 (a & ~b), TST=9 (a&b) and TEQ=10 (a^b). BIC clears each bit of a where b holds a 1.
- R4: For CMP, TST and TEQ, `result_q` still shows the computed value.
- R5: `dest_we_q` is 1 for codes 0 to 7 and 0 for codes 8 to 15.
- R6: For codes 0 to 7 with `set_flags` low, `flags_q` equals the incoming `flags_in`.
- R7: Codes 8, 9 and 10 update the flags whatever the level of `set_flags`.
- R8: The flag bits are N=bit 3, Z=bit 2, C=bit 1 and V=bit 0. On an update, N is result bit 31 and Z is 1 exactly when the result is zero.
- R9: On an update by an arithmetic code, C is the adder carry out. For a subtraction this means C=1 when no borrow occurs, so 1-1 gives Z=1 and C=1.
- R10: On an update, V reports signed overflow for arithmetic codes. Bitwise codes keep V from `flags_in`.
- R11: On an update by a bitwise code, C is taken from `shift_carry`.
- R12: Codes 11 to 15 give `result_q`=0 and `dest_we_q`=0, and `flags_q` equals `flags_in`.
- R13: The outputs show the inputs sampled at the previous rising edge, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry out of the shifter |
| set_flags | input | 1 | Request to update the flags |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result_q | output | 32 | Registered result |
| dest_we_q | output | 1 | Registered destination write strobe |
| flags_q | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
The bench targets the carry rules first:
- A design that takes a plain borrow for subtraction, rather than the inverted borrow, reports C=0 for 1-1.
- A design that feeds adder carry into bitwise operations ignores `shift_carry`.

It drives sign-boundary sums such as 0x7FFFFFFF+1. A design that forgets signed overflow, or that clears V on bitwise operations, fails there. It checks comparisons with `set_flags` low, which a design that gates every flag write on the request misses. It also checks operations with the request low that must hold the flags. Reverse subtract with swapped operand roles, bit clear with an inverted mask, and undefined codes that write anything are each caught by direct result and strobe checks.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_MOV = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ORR = 4'd4, OP_AND = 4'd5, OP_EOR = 4'd6,  OP_BIC = 4'd7,
    OP_CMP = 4'd8, OP_TST = 4'd9, OP_TEQ = 4'd10
  } op_e;

  localparam int F_N = 3;
  localparam int F_Z = 2;
  localparam int F_C = 1;
  localparam int F_V = 0;

  function automatic logic is_known(input logic [3:0] op);
    return op <= 4'd10;
  endfunction

  function automatic logic is_compare(input logic [3:0] op);
    return (op == OP_CMP) || (op == OP_TST) || (op == OP_TEQ);
  endfunction

  function automatic logic uses_adder(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_RSB) || (op == OP_CMP);
  endfunction
endpackage

// File: rtl/dp_alu_core.sv
module dp_alu_core
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output logic             add_c,
  output logic             add_v
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH:0] add_cin(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] y,
                                             input logic cin);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  endfunction

  logic [WIDTH-1:0] ax, ay;
  logic             cin;
  logic [WIDTH:0]   sum;

  // operand steering: subtract forms use x + ~y + 1
  always_comb begin
    ax  = a;
    ay  = b;
    cin = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin ay = ~b; cin = 1'b1; end
      OP_RSB:         begin ax = b; ay = ~a; cin = 1'b1; end
      default: ;
    endcase
  end

  assign sum   = add_cin(ax, ay, cin);
  assign add_c = sum[WIDTH];
  assign add_v = (ax[MSB] == ay[MSB]) && (sum[MSB] != ax[MSB]);

  always_comb begin
    case (op)
      OP_MOV:                         res = b;
      OP_ADD, OP_SUB, OP_RSB, OP_CMP: res = sum[MSB:0];
      OP_ORR:                         res = a | b;
      OP_AND, OP_TST:                 res = a & b;
      OP_EOR, OP_TEQ:                 res = a ^ b;
      OP_BIC:                         res = a & ~b;
      default:                        res = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] res,
  input  logic             add_c,
  input  logic             add_v,
  input  logic             shift_carry,
  input  logic             set_flags,
  input  logic [3:0]       flags_in,
  output logic             flag_upd,
  output logic [3:0]       flags_nxt
);
  localparam int MSB = WIDTH - 1;

  logic [3:0] calc;

  always_comb begin
    calc[F_N] = res[MSB];
    calc[F_Z] = (res == '0);
    calc[F_C] = uses_adder(op) ? add_c : shift_carry;
    calc[F_V] = uses_adder(op) ? add_v : flags_in[F_V];
    flag_upd  = is_known(op) && (set_flags || is_compare(op));
    flags_nxt = flag_upd ? calc : flags_in;
  end
endmodule

// File: rtl/dp_alu_unit.sv
module dp_alu_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             shift_carry,
  input  logic             set_flags,
  input  logic [3:0]       flags_in,
  output logic [WIDTH-1:0] result_q,
  output logic             dest_we_q,
  output logic [3:0]       flags_q
);
  logic [WIDTH-1:0] alu_res;
  logic             alu_c, alu_v;
  logic             flag_upd;
  logic [3:0]       flags_nxt;
  logic             dest_we;

  dp_alu_core #(.WIDTH(WIDTH)) u_core (
    .op    (op_code),
    .a     (opnd_a),
    .b     (opnd_b),
    .res   (alu_res),
    .add_c (alu_c),
    .add_v (alu_v)
  );

  dp_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .op          (op_code),
    .res         (alu_res),
    .add_c       (alu_c),
    .add_v       (alu_v),
    .shift_carry (shift_carry),
    .set_flags   (set_flags),
    .flags_in    (flags_in),
    .flag_upd    (flag_upd),
    .flags_nxt   (flags_nxt)
  );

  assign dest_we = is_known(op_code) && !is_compare(op_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q  <= '0;
      dest_we_q <= 1'b0;
      flags_q   <= '0;
    end else begin
      result_q  <= alu_res;
      dest_we_q <= dest_we;
      flags_q   <= flags_nxt;
    end
  end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic             shift_carry,
  input logic             set_flags,
  input logic [3:0]       flags_in,
  input logic [WIDTH-1:0] result_q,
  input logic             dest_we_q,
  input logic [3:0]       flags_q
);
  localparam int MSB = WIDTH - 1;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic bitwise_op;
  assign bitwise_op = (op_code == 4'd0) || (op_code >= 4'd4 && op_code <= 4'd7) ||
                      (op_code == 4'd9) || (op_code == 4'd10);

  // R5
  we_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (dest_we_q == ($past(op_code) < 4'd8)));

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(op_code) < 4'd8 && !$past(set_flags) |-> flags_q == $past(flags_in));

  // R12
  undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(op_code) > 4'd10 |-> flags_q == $past(flags_in) && result_q == '0);

  // R8
  nz_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(op_code) <= 4'd10 && ($past(set_flags) || $past(op_code) >= 4'd8)
    |-> flags_q[3] == result_q[MSB] && flags_q[2] == (result_q == '0));

  // R7
  cmp_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(op_code) == 4'd8 && $past(opnd_a) == $past(opnd_b)
    |-> flags_q[2] && flags_q[1]);

  // R11
  bitwise_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(bitwise_op) && ($past(set_flags) || $past(op_code) >= 4'd9)
    |-> flags_q[1] == $past(shift_carry) && flags_q[0] == $past(flags_in[0]));
endmodule

bind dp_alu_unit dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_code     (op_code),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .shift_carry (shift_carry),
  .set_flags   (set_flags),
  .flags_in    (flags_in),
  .result_q    (result_q),
  .dest_we_q   (dest_we_q),
  .flags_q     (flags_q)
);

// File: tb/dp_alu_unit_test.sv
module dp_alu_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        shift_carry = 1'b0, set_flags = 1'b0;
  logic [3:0]  flags_in = 4'd0;
  logic [31:0] result_q;
  logic        dest_we_q;
  logic [3:0]  flags_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_alu_unit uut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .shift_carry(shift_carry), .set_flags(set_flags), .flags_in(flags_in),
    .result_q(result_q), .dest_we_q(dest_we_q), .flags_q(flags_q)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  // reference written from the requirements in wide signed arithmetic
  function automatic void model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic sc, input logic sf, input logic [3:0] fl,
                                output logic [31:0] r, output logic we, output logic [3:0] f);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint s = 0;
    logic [32:0] u;
    logic c = sc, v;
    bit ar = 0;
    case (op)
      4'd0: r = b;
      4'd1: begin u = {1'b0, a} + {1'b0, b}; r = u[31:0]; c = u[32]; s = sa + sb; ar = 1; end
      4'd2, 4'd8: begin r = a - b; c = (a >= b); s = sa - sb; ar = 1; end
      4'd3: begin r = b - a; c = (b >= a); s = sb - sa; ar = 1; end
      4'd4: r = a | b;
      4'd5, 4'd9: r = a & b;
      4'd6, 4'd10: r = a ^ b;
      4'd7: r = a & ~b;
      default: r = 32'd0;
    endcase
    v  = ar ? (s > 64'sd2147483647 || s < -64'sd2147483648) : fl[0];
    we = (op < 4'd8);
    f  = (op <= 4'd10 && (sf || op >= 4'd8)) ? {r[31], r == 32'd0, c, v} : fl;
  endfunction

  logic [31:0] er;
  logic        ewe;
  logic [3:0]  ef;

  // drive at negedge, outputs settle after the next posedge, check at the following negedge
  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic sc, input logic sf, input logic [3:0] fl);
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b; shift_carry = sc; set_flags = sf; flags_in = fl;
    model(op, a, b, sc, sf, fl, er, ewe, ef);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string rt, ft;
    void'($urandom(32'd7351));
    // R1: reset state with busy inputs
    op_code = 4'd1; opnd_a = 32'h5; opnd_b = 32'h9; set_flags = 1'b1; flags_in = 4'hF;
    repeat (3) @(negedge clk);
    chk("R1 result", result_q, 32'd0);
    chk("R1 we", {31'd0, dest_we_q}, 32'd0);
    chk("R1 flags", {28'd0, flags_q}, 32'd0);
    rst_n = 1'b1;

    // R2: negate by reverse subtract
    run(4'd3, 32'h77, 32'h0, 0, 1, 4'b0000);
    chk("R2 rsb", result_q, 32'hFFFFFF89);
    chk("R9 rsb borrow", {28'd0, flags_q}, {28'd0, 4'b1000});
    // R9: 1 - 1 sets Z and C
    run(4'd2, 32'd1, 32'd1, 0, 1, 4'b0000);
    chk("R9 sub", {result_q[3:0], flags_q}, {4'd0, 4'b0110});
    // R3: bit clear
    run(4'd7, 32'hF, 32'h5, 0, 0, 4'b0000);
    chk("R3 bic", result_q, 32'hA);
    // R7: compare with set_flags low still updates; R4 result visible; R5 no write
    run(4'd8, 32'd4, 32'd4, 0, 0, 4'b0000);
    chk("R7 cmp flags", {28'd0, flags_q}, {28'd0, 4'b0110});
    chk("R4 cmp result", result_q, 32'd0);
    chk("R5 cmp we", {31'd0, dest_we_q}, 32'd0);
    // R10: signed overflow
    run(4'd1, 32'h7FFFFFFF, 32'd1, 0, 1, 4'b0000);
    chk("R10 add ovf", {28'd0, flags_q}, {28'd0, 4'b1001});
    // R9: unsigned carry out of add
    run(4'd1, 32'hFFFFFFFF, 32'd1, 0, 1, 4'b0001);
    chk("R9 add carry", {28'd0, flags_q}, {28'd0, 4'b0110});
    // R11 and R10: bitwise takes shifter carry, keeps V
    run(4'd4, 32'h0, 32'h0, 1, 1, 4'b0001);
    chk("R11 orr carry", {28'd0, flags_q}, {28'd0, 4'b0111});
    // R6: no set_flags keeps flags
    run(4'd2, 32'd1, 32'd1, 0, 0, 4'b1001);
    chk("R6 hold", {28'd0, flags_q}, {28'd0, 4'b1001});
    // R12: undefined code
    run(4'd13, 32'h1234, 32'h55, 1, 1, 4'b0101);
    chk("R12 undef", {result_q[30:0], dest_we_q}, 32'd0);
    chk("R12 flags", {28'd0, flags_q}, {28'd0, 4'b0101});
    // R13: new inputs do not show before the next edge
    run(4'd0, 32'd0, 32'hCAFE, 0, 0, 4'b0000);
    @(negedge clk);
    op_code = 4'd0; opnd_b = 32'hBEEF;
    #1;
    chk("R13 latency", result_q, 32'hCAFE);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  op = 4'($urandom_range(0, 15));
      logic [31:0] a  = $urandom;
      logic [31:0] b  = $urandom;
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) a = 32'h80000000;
      run(op, a, b, 1'($urandom), 1'($urandom), 4'($urandom));
      rt = (op > 4'd10) ? "R12" : ((op inside {4'd1, 4'd2, 4'd3, 4'd8}) ? "R2" : "R3");
      if (op > 4'd10)                         ft = "R12";
      else if (op >= 4'd8)                    ft = "R7";
      else if (!set_flags)                    ft = "R6";
      else                                    ft = "R8";
      chk(rt, result_q, er);
      chk("R5", {31'd0, dest_we_q}, {31'd0, ewe});
      chk(ft, {28'd0, flags_q}, {28'd0, ef});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule